// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a parallel input port and raises an active-low interrupt towards a host. It holds a reference copy of the port. As soon as the synchronized port value differs from that copy in any bit, it asks the open-drain pad to pull the interrupt line low. The request drops by itself if the pins go back to the reference value. It also drops when the host accesses the device, and the clear point depends on the access direction. A read clears on the SCL rising edge of the acknowledge bit. A write clears on the SCL falling edge of the acknowledge bit. Each such clear loads the current pin snapshot into the reference.

The serial protocol engine supplies four signals. Two are single-cycle SCL edge pulses. The other two are level strobes that stay high for the whole acknowledge bit of a read or a write addressed to this device. The engine raises neither strobe for traffic to other addresses.

The raw pins pass through a synchronizer of `SYNC_STAGES` flops before the comparison. The controller is a three-state machine:
- **ARMED**: no pending change.
- **ASSERTED**: the request is driven.
- **HOLDOFF**: an access clear has happened and the acknowledge bit is still running. In this state the reference follows the pins, so any change made during this window is absorbed.

Transitions:
- **ARMED → ASSERTED** on a difference.
- **ASSERTED → ARMED** when the pins revert.
- **ARMED/ASSERTED → HOLDOFF** on an access clear.
- **HOLDOFF → ARMED** once both acknowledge strobes are low.
- All other cases stay in the current state.

Top module: `port_change_irq`

## Requirements
- R1: After reset `irq_oe` is 0 and the reference is all ones. With every pin high, `irq_oe` stays 0.
- R2: A rising or a falling change of any single pin, relative to the reference, sets `irq_oe` to 1 on the third rising clock edge after the change (SYNC_STAGES+1 with the default of 2), and not earlier.
- R3: If the pins return to the reference value while `irq_oe` is 1 and no access clear occurs, `irq_oe` returns to 0 with the same three-edge latency.
- R4: An `scl_rise` pulse while `rd_ack_phase` is 1 sets `irq_oe` to 0 on the next clock edge and reloads the reference from the pins. An `scl_fall` pulse during a read acknowledge does not clear.
- R5: An `scl_fall` pulse while `wr_ack_phase` is 1 sets `irq_oe` to 0 on the next edge and reloads the reference. An `scl_rise` pulse during a write acknowledge does not clear.
- R6: SCL edge pulses while both acknowledge strobes are 0 leave `irq_oe` and the reference unchanged.
- R7: A pin change made between an access clear and the end of that acknowledge bit is absorbed into the reference and never raises `irq_oe`.
- R8: After the acknowledge bit ends, the next change against the new reference raises `irq_oe` with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_raw | input | PORT_W | Unsynchronized port pin levels |
| scl_rise | input | 1 | One-cycle pulse on an SCL low-to-high edge |
| scl_fall | input | 1 | One-cycle pulse on an SCL high-to-low edge |
| rd_ack_phase | input | 1 | High during the acknowledge bit of a read to this device |
| wr_ack_phase | input | 1 | High during the acknowledge bit of a write to this device |
| irq_oe | output | 1 | 1 = pad pulls the interrupt line low, 0 = released |

## Verification
The bench pins down the exact three-edge latency by checking one edge before the expected rise as well as at it. A design with the wrong synchronizer depth, or one that compares the raw pins, fails this check. Each access direction is tried with the wrong SCL edge, so a design that clears reads on the falling edge or writes on the rising edge keeps or drops the request at the wrong moment. A pin change made inside the acknowledge window must stay silent afterwards; a design that reloads the reference only once at the clear edge would raise a false request there. After each access clear the pins are moved back to their old value, and the bench expects a new request; a design that clears without reloading the reference would stay silent.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_ASSERTED = 2'd1,
        ST_HOLDOFF  = 2'd2
    } pcig_state_e;

endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/pcig_ref.sv
module pcig_ref #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] snap,
    output logic [W-1:0] ref_q,
    output logic         differs
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ref_q <= RST_VAL;
        else if (load) ref_q <= snap;
    end

    assign differs = |(snap ^ ref_q);

endmodule

// File: rtl/pcig_fsm.sv
module pcig_fsm
    import pcig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic differs,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic rd_ack_phase,
    input  logic wr_ack_phase,
    output logic ref_load,
    output logic irq_oe
);

    pcig_state_e state_q, state_nx;
    logic        clr_rd, clr_wr, clr_any, ack_busy;

    assign clr_rd   = rd_ack_phase & scl_rise;
    assign clr_wr   = wr_ack_phase & scl_fall;
    assign clr_any  = clr_rd | clr_wr;
    assign ack_busy = rd_ack_phase | wr_ack_phase;
    assign ref_load = clr_any | (state_q == ST_HOLDOFF);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (clr_any)      state_nx = ST_HOLDOFF;
                else if (differs) state_nx = ST_ASSERTED;
            end
            ST_ASSERTED: begin
                if (clr_any)       state_nx = ST_HOLDOFF;
                else if (!differs) state_nx = ST_ARMED;
            end
            ST_HOLDOFF: begin
                if (!ack_busy && !clr_any) state_nx = ST_ARMED;
            end
            default: state_nx = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_oe <= 1'b0;
        else        irq_oe <= (state_nx == ST_ASSERTED);
    end

    AST_ARMED_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && differs && !clr_any) |=> irq_oe); // R2
    AST_REVERT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTED && !differs && !clr_any) |=> !irq_oe); // R3
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_phase && scl_rise) |=> !irq_oe); // R4
    AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack_phase && scl_fall) |=> !irq_oe); // R5
    AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERTED && differs && !rd_ack_phase && !wr_ack_phase) |=> irq_oe); // R6
    AST_HOLDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF) |=> !irq_oe); // R7

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_raw,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              rd_ack_phase,
    input  logic              wr_ack_phase,
    output logic              irq_oe
);

    localparam logic [PORT_W-1:0] IDLE_LEVEL = '1;

    logic [PORT_W-1:0] snap, ref_q;
    logic              differs, ref_load;

    pcig_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (port_raw),
        .d_out (snap)
    );

    pcig_ref #(.W(PORT_W), .RST_VAL(IDLE_LEVEL)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ref_load),
        .snap    (snap),
        .ref_q   (ref_q),
        .differs (differs)
    );

    pcig_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .differs      (differs),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .rd_ack_phase (rd_ack_phase),
        .wr_ack_phase (wr_ack_phase),
        .ref_load     (ref_load),
        .irq_oe       (irq_oe)
    );

    AST_RESET_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_q == IDLE_LEVEL)); // R1
    AST_FOREIGN_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_load) |=> $stable(ref_q)); // R6

endmodule

// File: tb/port_change_irq_tb.sv
module port_change_irq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_raw = 8'hFF;
    logic       scl_rise = 1'b0, scl_fall = 1'b0;
    logic       rd_ack_phase = 1'b0, wr_ack_phase = 1'b0;
    logic       irq_oe;
    int         total = 0, bad = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    port_change_irq dut_i (
        .clk(clk), .rst_n(rst_n), .port_raw(port_raw),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .rd_ack_phase(rd_ack_phase), .wr_ack_phase(wr_ack_phase),
        .irq_oe(irq_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        total++;
        if (irq_oe !== exp) begin
            bad++;
            $display("FAIL %s: irq_oe actual=%b expected=%b at %0t", req, irq_oe, exp, $time);
        end
    endtask

    task automatic pulse_rise();
        scl_rise = 1'b1; tick(1); scl_rise = 1'b0;
    endtask

    task automatic pulse_fall();
        scl_fall = 1'b1; tick(1); scl_fall = 1'b0;
    endtask

    task automatic end_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        tick(3);
        check("R1", 1'b0);
        rst_n = 1'b1;
        tick(6);
        check("R1", 1'b0);
    endtask

    task automatic t_edge_and_revert();
        port_raw = 8'h7F;              // bit 7 falls
        tick(2); check("R2", 1'b0);
        tick(1); check("R2", 1'b1);
        port_raw = 8'hFF;              // back to reference
        tick(2); check("R3", 1'b1);
        tick(1); check("R3", 1'b0);
    endtask

    task automatic t_read_clear();
        port_raw = 8'hA5;
        tick(3); check("R2", 1'b1);
        rd_ack_phase = 1'b1;
        pulse_fall();
        check("R4", 1'b1);             // wrong edge for a read
        pulse_rise();
        check("R4", 1'b0);
        tick(2); rd_ack_phase = 1'b0;
        tick(4); check("R4", 1'b0);    // reference now A5
        port_raw = 8'hFF;
        tick(3); check("R4", 1'b1);    // old value now differs
    endtask

    task automatic t_write_clear();
        wr_ack_phase = 1'b1;
        pulse_rise();
        check("R5", 1'b1);             // wrong edge for a write
        pulse_fall();
        check("R5", 1'b0);
        wr_ack_phase = 1'b0;
        tick(4); check("R5", 1'b0);    // reference now FF
        port_raw = 8'hA5;
        tick(3); check("R5", 1'b1);
    endtask

    task automatic t_foreign();
        for (int i = 0; i < 3; i++) begin
            pulse_rise(); tick(1); pulse_fall(); tick(1);
        end
        check("R6", 1'b1);
        port_raw = 8'hFF;              // reference untouched: still FF
        tick(3); check("R6", 1'b0);
    endtask

    task automatic t_holdoff_loss();
        rd_ack_phase = 1'b1;
        pulse_rise();
        port_raw = 8'h3C;
        tick(4); check("R7", 1'b0);
        rd_ack_phase = 1'b0;
        tick(5); check("R7", 1'b0);
    endtask

    task automatic t_rearm();
        port_raw = 8'h3D;              // bit 0 rises against 3C
        tick(2); check("R8", 1'b0);
        tick(1); check("R8", 1'b1);
        check("R2", 1'b1);
    endtask

    initial begin
        t_reset();
        t_edge_and_revert();
        t_read_clear();
        t_write_clear();
        t_foreign();
        t_holdoff_loss();
        t_rearm();
        end_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        end_run();
    end

endmodule